// File: doc/BRIEF.md
# Two-Window Memory Bank Mapper

This block sits between an 8-bit processor, which addresses 64KB, and a 512KB RAM. It splits the processor's space into a lower and an upper 32KB window. Each window can point at any one of sixteen 32KB physical banks. The block turns each processor address into a full 19-bit RAM address: the window's 4-bit bank number on top, followed by the 15 offset bits of the processor address unchanged.

Both bank numbers live in one 8-bit register. The processor loads it with an I/O write to any port from 70h to 7Fh. Only the low address byte is decoded, and its low nibble is ignored. The register cannot be read back. It has no reset value, so the mapping is arbitrary until software writes it for the first time.

A write is taken once, on the cycle the qualified strobe first becomes active. The qualified strobe is I/O request and write both asserted while the opcode-fetch signal is inactive. The block also produces the RAM enable, which is active only for memory cycles.

Top module: `bank_window_mapper`

## Requirements
- R1: For processor addresses 0000h-7FFFh, `phys_addr[18:15]` equals bits 3:0 of the bank register.
- R2: For processor addresses 8000h-FFFFh, `phys_addr[18:15]` equals bits 7:4 of the bank register.
- R3: `phys_addr[14:0]` always equals `cpu_addr[14:0]`. After the register is loaded with 10h, `phys_addr` equals `{3'b000, cpu_addr}`.
- R4: An I/O write loads the register from `cpu_data` when `cpu_addr[7:4]` is 7h, whatever the values of `cpu_addr[3:0]` and `cpu_addr[15:8]`.
- R5: An I/O write whose `cpu_addr[7:4]` is not 7h leaves the register unchanged.
- R6: A write is taken only when `iorq_n`=0, `wr_n`=0 and `m1_n`=1. A cycle with `m1_n`=0, or a memory write (`mreq_n`=0, `iorq_n`=1), leaves the register unchanged.
- R7: An I/O read (`iorq_n`=0, `wr_n`=1) in the port range leaves the register unchanged. The block has no data output.
- R8: One strobe assertion loads the register once, with the data present at the first rising clock edge of that assertion. Later data changes while the strobe is still held are ignored.
- R9: `ram_en` is 1 exactly when `mreq_n`=0 and `iorq_n`=1.
- R10: `rst` does not change the bank register. A mapping written before reset is still in force after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the strobe is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the strobe edge detector only |
| cpu_addr | input | 16 | Processor address bus |
| cpu_data | input | 8 | Processor data bus (write data) |
| iorq_n | input | 1 | I/O request, active low |
| mreq_n | input | 1 | Memory request, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / interrupt acknowledge, active low |
| phys_addr | output | 19 | Translated RAM address |
| ram_en | output | 1 | RAM enable, active high |

## Verification
The bench builds the block with its default parameters: a 16-bit processor address, a 19-bit physical address, 4-bit bank fields and port tag 7h. These values put every bank number in both windows, and every mirror port of the 70h-7Fh range, within reach of the random stimulus. Random writes are steered half the time to the port range, with random control-line combinations. This exercises both acceptance and rejection of writes.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

    localparam int CPU_AW   = 16;
    localparam int PHYS_AW  = 19;
    localparam int WIN_AW   = CPU_AW - 1;
    localparam int BANK_W   = PHYS_AW - WIN_AW;
    localparam int NUM_WIN  = 2;
    localparam int DATA_W   = NUM_WIN * BANK_W;
    localparam int IO_AW    = 8;
    localparam int MIRROR_W = 4;
    localparam logic [IO_AW-MIRROR_W-1:0] PORT_TAG = 4'h7;

    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        bank_t upper;
        bank_t lower;
    } bank_pair_t;

    // Decoded bus controls, active high
    typedef struct packed {
        logic iorq;
        logic mreq;
        logic wr;
        logic m1;
    } bus_ctl_t;

    function automatic logic port_match(input logic [IO_AW-1:0] a);
        return a[IO_AW-1:MIRROR_W] == PORT_TAG;
    endfunction

    function automatic bus_ctl_t decode_ctl(input logic iorq_n, input logic mreq_n,
                                            input logic wr_n, input logic m1_n);
        bus_ctl_t c;
        c.iorq = ~iorq_n;
        c.mreq = ~mreq_n;
        c.wr   = ~wr_n;
        c.m1   = ~m1_n;
        return c;
    endfunction

endpackage

// File: rtl/bm_port_decode.sv
module bm_port_decode
    import bankmap_pkg::*;
#(
    parameter int AW = IO_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] io_addr,
    input  bus_ctl_t      ctl,
    output logic          wr_pulse
);

    logic qual;
    logic qual_q;

    // Qualified I/O write: request + write, not an acknowledge/fetch cycle
    assign qual = ctl.iorq & ctl.wr & ~ctl.m1 & port_match(io_addr);

    always_ff @(posedge clk) begin
        if (rst) qual_q <= 1'b0;
        else     qual_q <= qual;
    end

    assign wr_pulse = qual & ~qual_q;

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);                                      // R8
    AST_PULSE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> (ctl.iorq && ctl.wr && !ctl.m1));                // R6

endmodule

// File: rtl/bm_bank_reg.sv
module bm_bank_reg
    import bankmap_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output bank_pair_t    banks
);

    logic [DW-1:0] bank_q;

    // Deliberately no reset: contents are undefined until first written
    always_ff @(posedge clk) begin
        if (wr_en) bank_q <= wr_data;
    end

    assign banks = bank_pair_t'(bank_q);

    AST_CAPTURE_DATA: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (bank_q == $past(wr_data)));                        // R4
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(bank_q));                                  // R7

endmodule

// File: rtl/bm_window_xlate.sv
module bm_window_xlate
    import bankmap_pkg::*;
#(
    parameter int AW = CPU_AW,
    parameter int BW = BANK_W,
    parameter int NW = NUM_WIN
) (
    input  logic [AW-1:0]         cpu_addr,
    input  logic [NW*BW-1:0]      bank_bits,
    input  bus_ctl_t              ctl,
    output logic [BW+AW-2:0]      phys_addr,
    output logic                  ram_en
);

    localparam int OFS_W = AW - 1;

    logic [BW-1:0] win_bank [NW];

    for (genvar w = 0; w < NW; w++) begin : g_win
        assign win_bank[w] = bank_bits[w*BW +: BW];
    end

    logic [BW-1:0] sel_bank;
    assign sel_bank  = win_bank[cpu_addr[AW-1]];
    assign phys_addr = {sel_bank, cpu_addr[OFS_W-1:0]};
    assign ram_en    = ctl.mreq & ~ctl.iorq;

endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
    import bankmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_data,
    input  logic               iorq_n,
    input  logic               mreq_n,
    input  logic               wr_n,
    input  logic               m1_n,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic               ram_en
);

    bus_ctl_t   ctl;
    logic       wr_pulse;
    bank_pair_t banks;

    assign ctl = decode_ctl(iorq_n, mreq_n, wr_n, m1_n);

    bm_port_decode #(.AW(IO_AW)) u_decode (
        .clk      (clk),
        .rst      (rst),
        .io_addr  (cpu_addr[IO_AW-1:0]),
        .ctl      (ctl),
        .wr_pulse (wr_pulse)
    );

    bm_bank_reg #(.DW(DATA_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_pulse),
        .wr_data (cpu_data),
        .banks   (banks)
    );

    bm_window_xlate #(.AW(CPU_AW), .BW(BANK_W), .NW(NUM_WIN)) u_xlate (
        .cpu_addr  (cpu_addr),
        .bank_bits (banks),
        .ctl       (ctl),
        .phys_addr (phys_addr),
        .ram_en    (ram_en)
    );

    AST_CE_NOT_IO: assert property (@(posedge clk) disable iff (rst)
        !iorq_n |-> !ram_en);                                         // R9
    AST_CE_NEEDS_MREQ: assert property (@(posedge clk) disable iff (rst)
        ram_en |-> !mreq_n);                                          // R9
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        phys_addr[CPU_AW-2:0] == cpu_addr[CPU_AW-2:0]);               // R3

endmodule

// File: tb/bank_window_mapper_tb.sv
`timescale 1ns/1ps
module bank_window_mapper_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic        iorq_n, mreq_n, wr_n, m1_n;
    logic [18:0] phys_addr;
    logic        ram_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [7:0] model;

    always #2.5 clk = ~clk;

    bank_window_mapper dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .iorq_n(iorq_n), .mreq_n(mreq_n), .wr_n(wr_n), .m1_n(m1_n),
        .phys_addr(phys_addr), .ram_en(ram_en)
    );

    function automatic logic [18:0] exp_phys(input logic [7:0] m, input logic [15:0] a);
        return {a[15] ? m[7:4] : m[3:0], a[14:0]};
    endfunction

    function automatic bit exp_take(input logic io_n, input logic w_n,
                                    input logic f_n, input logic [15:0] a);
        return !io_n && !w_n && f_n && (a[7:4] == 4'h7);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        iorq_n = 1; mreq_n = 1; wr_n = 1; m1_n = 1;
    endtask

    // One bus cycle held for one rising edge, then an idle edge
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                             input logic io_n, input logic mr_n,
                             input logic w_n, input logic f_n);
        @(negedge clk);
        cpu_addr = a; cpu_data = d;
        iorq_n = io_n; mreq_n = mr_n; wr_n = w_n; m1_n = f_n;
        if (exp_take(io_n, w_n, f_n, a)) model = d;
        @(negedge clk);
        idle();
        @(negedge clk);
    endtask

    task automatic probe(input string req, input logic [15:0] a);
        @(negedge clk);
        idle();
        cpu_addr = a; mreq_n = 0;
        #1;
        check(req, {13'd0, phys_addr}, {13'd0, exp_phys(model, a)});
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        cpu_addr = 0; cpu_data = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        #1 check("R9 reset idle ram_en", {31'd0, ram_en}, 32'd0);
        rst = 0;

        // R3 linear map with 10h
        bus_write(16'h0070, 8'h10, 0, 1, 0, 1);
        probe("R3 linear low", 16'h1234);
        probe("R3 linear high", 16'h9234);

        // R4 mirror port, high byte ignored; R1/R2 window fields
        bus_write(16'hC37F, 8'hA5, 0, 1, 0, 1);
        probe("R1 lower window", 16'h0000);
        probe("R2 upper window", 16'hFFFF);
        probe("R1 lower edge", 16'h7FFF);
        probe("R2 upper edge", 16'h8000);

        // R5 ports outside range
        bus_write(16'h006F, 8'h33, 0, 1, 0, 1);
        bus_write(16'h0080, 8'h33, 0, 1, 0, 1);
        probe("R5 out-of-range port", 16'h8001);
        probe("R5 out-of-range port", 16'h0001);

        // R6 fetch/ack cycle and memory write ignored
        bus_write(16'h0075, 8'h66, 0, 1, 0, 0);
        bus_write(16'h0070, 8'h66, 1, 0, 0, 1);
        probe("R6 m1 or mem write ignored", 16'hABCD);
        probe("R6 m1 or mem write ignored", 16'h2BCD);

        // R7 I/O read ignored
        bus_write(16'h0072, 8'h99, 0, 1, 1, 1);
        probe("R7 io read ignored", 16'hF000);
        probe("R7 io read ignored", 16'h7000);

        // R8 strobe held across two edges with data change
        @(negedge clk);
        cpu_addr = 16'h0077; cpu_data = 8'h3C;
        iorq_n = 0; wr_n = 0; m1_n = 1; mreq_n = 1;
        @(negedge clk);
        cpu_data = 8'hC3;
        @(negedge clk);
        idle();
        model = 8'h3C;
        probe("R8 first data kept", 16'h0100);
        probe("R8 first data kept", 16'h8100);

        // R10 reset leaves mapping
        @(negedge clk); rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        probe("R10 mapping after reset", 16'h4444);
        probe("R10 mapping after reset", 16'hC444);

        // R9 enable combinations
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            idle();
            mreq_n = k[0]; iorq_n = k[1];
            #1 check("R9 ram_en", {31'd0, ram_en}, {31'd0, (!k[0] && k[1])});
        end

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            logic [3:0]  c;
            a = 16'($urandom);
            d = 8'($urandom);
            c = 4'($urandom);
            if ($urandom % 2 == 0) a[7:4] = 4'h7;
            if ($urandom % 4 != 0) c = 4'b0101; // plain I/O write bias
            bus_write(a, d, c[3], c[2], c[1], c[0]);
            a = 16'($urandom);
            @(negedge clk);
            cpu_addr = a;
            mreq_n = 1'($urandom);
            iorq_n = 1'($urandom);
            wr_n = 1; m1_n = 1;
            #1;
            check(a[15] ? "R2 random" : "R1 random", {13'd0, phys_addr},
                  {13'd0, exp_phys(model, a)});
            check("R9 random", {31'd0, ram_en}, {31'd0, (!mreq_n && iorq_n)});
            @(negedge clk);
            idle();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule